// File: doc/BRIEF.md
# Register-Programmed Watchdog Timer

This block is a watchdog timer driven through a small register port. Software writes a timeout into the reload register while the timer is stopped. It then starts the timer by changing the run-code field of the control register. While the timer runs, software must write to the live-count register often enough to keep it from reaching zero. Each such write copies the reload value back into the live count. The reload register cannot be changed while the timer runs, so a program that has gone wrong cannot stretch its own timeout.

When the live count reaches zero while the timer is running, the block does three things. It latches a sticky timeout flag in the control register. It emits a single one-cycle pulse on the event output picked by a 2-bit selector, which can also select no output at all. The live count then stays at zero until it is reloaded. The flag is cleared by writing a one to it.

The register port accepts one access per cycle when `acc_valid` is high. It is always ready and never applies back-pressure. Every access gets exactly one response in the following cycle. That response cannot be stalled, so a master must accept it in that cycle.

Top module: `sentry_timer`

## Requirements
- R1: After reset, the control register reads 0x0AD6 (stopped, selector = none), and the reload and live-count registers read 0. All event outputs are low.
- R2: The timer runs whenever control bits [11:4] hold any value other than 0xAD. While it runs, the live count falls by one per clock until it reaches zero.
- R3: A write to the reload register (byte offset 0x4) while stopped stores the value and also copies it into the live count. While running, such a write is ignored and the reload value is kept.
- R4: A write of any value to the live-count register (byte offset 0x8) while running reloads the live count from the reload register. While stopped, such a write changes nothing.
- R5: On a clock edge where the timer runs and the live count is zero, control bit 15 (timeout flag) is set. The live count stays at zero until reloaded. A timeout fires only once per reload.
- R6: Writing control (byte offset 0x0) stores bits [14:0] as written. For bit 15, writing 1 clears the flag and writing 0 leaves it unchanged. If a timeout sets the flag on the same edge as a clearing write, the set wins.
- R7: Control bits [2:1] select the timeout action: 00 = `evt_reset`, 01 = `evt_nmi`, 10 = `evt_gpi`, 11 = none. The selected output pulses high for exactly one cycle. The pulse appears in the same cycle in which the flag first reads as set. At most one event output is high at a time.
- R8: `acc_size` encodes 01 = 16-bit and 10 = 32-bit. Control must be accessed with 16-bit size, and the reload and live-count registers with 32-bit size. A size mismatch or an unmapped offset gives `rsp_err` = 1 and `rsp_rdata` = 0, and any write in such an access is discarded.
- R9: Every access gets a response in the next cycle: `rsp_valid` is high for one cycle. For a good read, `rsp_rdata` carries the register value as it was before that access's clock edge, with control zero-extended to 32 bits. Writes return data 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte offset of the register |
| acc_size | input | 2 | Access size code |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Access rejected (size or offset) |
| rsp_rdata | output | 32 | Read data |
| evt_reset | output | 1 | Timeout pulse, reset action |
| evt_nmi | output | 1 | Timeout pulse, non-maskable interrupt action |
| evt_gpi | output | 1 | Timeout pulse, general interrupt action |

## Verification
The assertions check, on every cycle, a set of invariants:
- the event outputs are mutually exclusive and each pulse lasts one cycle;
- every pulse coincides with a set timeout flag;
- a reload write while running leaves the reload register unchanged;
- a live count at zero stays at zero unless it is reloaded;
- the live count stays unchanged while the timer is stopped;
- every access gets a response, and a wrongly sized control access is rejected.

Only the bench's scenarios can show the rest:
- the count reaches zero at the expected time after kicks;
- a timeout fires once per reload;
- the write-one-to-clear behaviour of the flag is correct;
- each selector value drives the right output.

// File: rtl/sentry_pkg.sv
package sentry_pkg;
  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_16   = 2'b01,
    SZ_32   = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    EV_RESET = 2'b00,
    EV_NMI   = 2'b01,
    EV_GPI   = 2'b10,
    EV_NONE  = 2'b11
  } evt_sel_e;

  localparam int N_EVT = 3;

  localparam logic [3:0] OFS_CTL  = 4'h0;
  localparam logic [3:0] OFS_CNT  = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h8;
endpackage

// File: rtl/sentry_bus.sv
module sentry_bus
  import sentry_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CTL_W  = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [CTL_W-1:0]  ctl_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CNT_W-1:0]  stat_q,
  output logic              ctl_wr,
  output logic              cnt_wr,
  output logic              stat_wr,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic hit_ctl, hit_cnt, hit_stat, size_ok, good;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    hit_ctl  = (acc_addr == ADDR_W'(OFS_CTL));
    hit_cnt  = (acc_addr == ADDR_W'(OFS_CNT));
    hit_stat = (acc_addr == ADDR_W'(OFS_STAT));
    if (hit_ctl)
      size_ok = (acc_size == SZ_16);
    else if (hit_cnt || hit_stat)
      size_ok = (acc_size == SZ_32);
    else
      size_ok = 1'b0;
    good = acc_valid && size_ok;
    ctl_wr  = good && acc_write && hit_ctl;
    cnt_wr  = good && acc_write && hit_cnt;
    stat_wr = good && acc_write && hit_stat;
    if (hit_ctl)
      rd_mux = DATA_W'(ctl_q);
    else if (hit_cnt)
      rd_mux = DATA_W'(cnt_q);
    else
      rd_mux = DATA_W'(stat_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_err   <= acc_valid && !size_ok;
      rsp_rdata <= (good && !acc_write) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/sentry_core.sv
module sentry_core #(
  parameter int               CTL_W    = 16,
  parameter int               CNT_W    = 32,
  parameter int               EN_LSB   = 4,
  parameter int               EN_W     = 8,
  parameter logic [EN_W-1:0]  DIS_CODE = 8'hAD,
  parameter int               RO_BIT   = 15,
  parameter logic [CTL_W-1:0] CTL_RST  = 16'h0AD6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             cnt_wr,
  input  logic             stat_wr,
  input  logic [CTL_W-1:0] ctl_val,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] stat_q,
  output logic             running,
  output logic             expire
);
  logic             fired_q;
  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    running = (ctl_q[EN_LSB +: EN_W] != DIS_CODE);
    expire  = running && (stat_q == '0) && !fired_q;
    ctl_d   = ctl_q;
    if (ctl_wr) begin
      ctl_d         = ctl_val;
      ctl_d[RO_BIT] = ctl_q[RO_BIT] & ~ctl_val[RO_BIT];
    end
    if (expire)
      ctl_d[RO_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctl_q <= CTL_RST;
    else
      ctl_q <= ctl_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stat_q  <= '0;
      fired_q <= 1'b0;
    end else if (cnt_wr && !running) begin
      cnt_q   <= cnt_val;
      stat_q  <= cnt_val;
      fired_q <= 1'b0;
    end else if (stat_wr && running) begin
      stat_q  <= cnt_q;
      fired_q <= 1'b0;
    end else if (expire) begin
      fired_q <= 1'b1;
    end else if (running && stat_q != '0) begin
      stat_q  <= stat_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sentry_event.sv
module sentry_event #(
  parameter int N_OUT = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic [SEL_W-1:0] sel,
  output logic [N_OUT-1:0] evt_q
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rst_n)
        evt_q[i] <= 1'b0;
      else
        evt_q[i] <= expire && (sel == SEL_W'(i));
    end
  end
endmodule

// File: rtl/sentry_timer.sv
module sentry_timer
  import sentry_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter int              DATA_W   = 32,
  parameter int              CTL_W    = 16,
  parameter int              CNT_W    = 32,
  parameter int              EN_LSB   = 4,
  parameter int              EN_W     = 8,
  parameter logic [EN_W-1:0] DIS_CODE = 8'hAD,
  parameter int              SEL_LSB  = 1,
  parameter int              RO_BIT   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              evt_reset,
  output logic              evt_nmi,
  output logic              evt_gpi
);
  localparam int SEL_W = 2;
  localparam logic [CTL_W-1:0] CTL_RST =
    (CTL_W'(DIS_CODE) << EN_LSB) | (CTL_W'(EV_NONE) << SEL_LSB);

  logic             ctl_wr, cnt_wr, stat_wr, running, expire;
  logic [CTL_W-1:0] ctl_q;
  logic [CNT_W-1:0] cnt_q, stat_q;
  logic [N_EVT-1:0] evt_q;

  sentry_bus #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_W(CTL_W), .CNT_W(CNT_W)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .ctl_q(ctl_q), .cnt_q(cnt_q),
    .stat_q(stat_q), .ctl_wr(ctl_wr), .cnt_wr(cnt_wr), .stat_wr(stat_wr),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  sentry_core #(
    .CTL_W(CTL_W), .CNT_W(CNT_W), .EN_LSB(EN_LSB), .EN_W(EN_W),
    .DIS_CODE(DIS_CODE), .RO_BIT(RO_BIT), .CTL_RST(CTL_RST)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .cnt_wr(cnt_wr),
    .stat_wr(stat_wr), .ctl_val(acc_wdata[CTL_W-1:0]),
    .cnt_val(acc_wdata[CNT_W-1:0]), .ctl_q(ctl_q), .cnt_q(cnt_q),
    .stat_q(stat_q), .running(running), .expire(expire)
  );

  sentry_event #(.N_OUT(N_EVT), .SEL_W(SEL_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .expire(expire),
    .sel(ctl_q[SEL_LSB +: SEL_W]), .evt_q(evt_q)
  );

  assign evt_reset = evt_q[0];
  assign evt_nmi   = evt_q[1];
  assign evt_gpi   = evt_q[2];
endmodule

// File: rtl/sentry_timer_chk.sv
module sentry_timer_chk #(
  parameter int ADDR_W = 4,
  parameter int CTL_W  = 16,
  parameter int CNT_W  = 32,
  parameter int RO_BIT = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_size,
  input logic              running,
  input logic [CTL_W-1:0]  ctl_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  stat_q,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              evt_reset,
  input logic              evt_nmi,
  input logic              evt_gpi
);
  logic wr_cnt, wr_stat;
  assign wr_cnt  = acc_valid && acc_write && (acc_addr == ADDR_W'(4));
  assign wr_stat = acc_valid && acc_write && (acc_addr == ADDR_W'(8));

  assert_evt_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_reset, evt_nmi, evt_gpi}));

  assert_evt_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_reset || evt_nmi || evt_gpi) |=> !(evt_reset || evt_nmi || evt_gpi));

  assert_evt_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_reset || evt_nmi || evt_gpi) |-> ctl_q[RO_BIT]);

  assert_reload_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr_cnt) |=> $stable(cnt_q));

  assert_zero_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && stat_q == '0 && !wr_stat && !wr_cnt) |=> (stat_q == '0));

  assert_stopped_static_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_cnt) |=> $stable(stat_q));

  assert_ctl_size_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr == ADDR_W'(0) && acc_size != 2'b01) |=> rsp_err);

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);
endmodule

bind sentry_timer sentry_timer_chk #(
  .ADDR_W(ADDR_W), .CTL_W(CTL_W), .CNT_W(CNT_W), .RO_BIT(RO_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_size(acc_size), .running(running),
  .ctl_q(ctl_q), .cnt_q(cnt_q), .stat_q(stat_q), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .evt_reset(evt_reset), .evt_nmi(evt_nmi),
  .evt_gpi(evt_gpi)
);

// File: tb/sentry_timer_test.sv
`timescale 1ns/1ps
module sentry_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic        rsp_valid, rsp_err, evt_reset, evt_nmi, evt_gpi;
  logic [31:0] rsp_rdata;

  int checks = 0, fails = 0;
  int n_reset = 0, n_nmi = 0, n_gpi = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sentry_timer uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .evt_reset(evt_reset), .evt_nmi(evt_nmi), .evt_gpi(evt_gpi)
  );

  // Behavioural reference model, advanced on every rising edge.
  logic [15:0] m_ctl;
  logic [31:0] m_cnt, m_stat, e_rd, rd_sel;
  logic        m_fired, e_rsp, e_err, m_run, m_ok, m_exp;
  logic [2:0]  e_ev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 16'h0AD6; m_cnt = 0; m_stat = 0; m_fired = 0;
      e_rsp = 0; e_err = 0; e_rd = 0; e_ev = 0;
    end else begin
      m_run = (m_ctl[11:4] != 8'hAD);
      m_ok = 0; rd_sel = 0;
      if (acc_addr == 4'h0) begin m_ok = (acc_size == 2'b01); rd_sel = {16'h0, m_ctl}; end
      else if (acc_addr == 4'h4) begin m_ok = (acc_size == 2'b10); rd_sel = m_cnt; end
      else if (acc_addr == 4'h8) begin m_ok = (acc_size == 2'b10); rd_sel = m_stat; end
      e_rsp = acc_valid;
      e_err = acc_valid && !m_ok;
      e_rd  = (acc_valid && m_ok && !acc_write) ? rd_sel : 32'h0;
      m_exp = m_run && m_stat == 0 && !m_fired;
      e_ev = 0;
      if (m_exp) begin
        case (m_ctl[2:1])
          2'b00: e_ev = 3'b001;
          2'b01: e_ev = 3'b010;
          2'b10: e_ev = 3'b100;
          default: e_ev = 3'b000;
        endcase
      end
      if (acc_valid && m_ok && acc_write && acc_addr == 4'h4 && !m_run) begin
        m_cnt = acc_wdata; m_stat = acc_wdata; m_fired = 0;
      end else if (acc_valid && m_ok && acc_write && acc_addr == 4'h8 && m_run) begin
        m_stat = m_cnt; m_fired = 0;
      end else if (m_exp) begin
        m_fired = 1;
      end else if (m_run && m_stat != 0) begin
        m_stat = m_stat - 1;
      end
      if (acc_valid && m_ok && acc_write && acc_addr == 4'h0)
        m_ctl = {m_ctl[15] & ~acc_wdata[15], acc_wdata[14:0]};
      if (m_exp) m_ctl[15] = 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rsp_valid == e_rsp && rsp_err == e_err, "R8/R9 response flags",
            {30'h0, rsp_valid, rsp_err}, {30'h0, e_rsp, e_err});
      check(rsp_rdata == e_rd, "R9 read data", rsp_rdata, e_rd);
      check({evt_gpi, evt_nmi, evt_reset} == e_ev, "R7 event outputs",
            {29'h0, evt_gpi, evt_nmi, evt_reset}, {29'h0, e_ev});
      if (evt_reset) n_reset++;
      if (evt_nmi) n_nmi++;
      if (evt_gpi) n_gpi++;
    end
  end

  task automatic access(input bit wr, input logic [3:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic er);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_addr = a; acc_size = sz; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d; logic e;
    idle(3);
    rst_n = 1;
    // R1 reset state
    check(!evt_reset && !evt_nmi && !evt_gpi, "R1 events low", {29'h0, evt_gpi, evt_nmi, evt_reset}, 0);
    access(0, 4'h0, 2'b01, 0, d, e); check(d == 32'h0AD6 && !e, "R1 control reset", d, 32'h0AD6);
    access(0, 4'h4, 2'b10, 0, d, e); check(d == 0, "R1 reload reset", d, 0);
    access(0, 4'h8, 2'b10, 0, d, e); check(d == 0, "R1 count reset", d, 0);
    // R8 size and offset errors
    access(0, 4'h0, 2'b10, 0, d, e); check(e == 1 && d == 0, "R8 control 32-bit read", {31'h0, e}, 1);
    access(0, 4'hC, 2'b10, 0, d, e); check(e == 1, "R8 unmapped offset", {31'h0, e}, 1);
    access(0, 4'h4, 2'b01, 0, d, e); check(e == 1, "R8 reload 16-bit read", {31'h0, e}, 1);
    // R3 reload while stopped copies into live count
    access(1, 4'h4, 2'b10, 32'd20, d, e);
    access(0, 4'h8, 2'b10, 0, d, e); check(d == 20, "R3 copy to live count", d, 20);
    // R4 kick while stopped has no effect
    access(1, 4'h8, 2'b10, 32'd7, d, e);
    access(0, 4'h8, 2'b10, 0, d, e); check(d == 20, "R4 kick ignored when stopped", d, 20);
    // R2 start with selector NMI
    access(1, 4'h0, 2'b01, 32'h0002, d, e);
    idle(2);
    access(0, 4'h8, 2'b10, 0, d, e); check(d < 20, "R2 counting down", d, 20);
    // R3 reload locked while running
    access(1, 4'h4, 2'b10, 32'd5, d, e);
    access(0, 4'h4, 2'b10, 0, d, e); check(d == 20, "R3 reload locked", d, 20);
    // R4 kicks
    for (int k = 0; k < 3; k++) begin
      access(1, 4'h8, 2'b10, 32'hFFFF, d, e);
      idle(6);
    end
    check(n_nmi == 0, "R4 kicks prevent timeout", n_nmi, 0);
    idle(40);
    check(n_nmi == 1 && n_reset == 0 && n_gpi == 0, "R7 NMI selected", n_nmi, 1);
    access(0, 4'h0, 2'b01, 0, d, e); check(d[15] == 1, "R5 flag set", d, 32'h8002);
    access(0, 4'h8, 2'b10, 0, d, e); check(d == 0, "R5 count held at zero", d, 0);
    idle(20);
    check(n_nmi == 1, "R5 single timeout per reload", n_nmi, 1);
    // R6 write-one-to-clear
    access(1, 4'h0, 2'b01, 32'h0002, d, e);
    access(0, 4'h0, 2'b01, 0, d, e); check(d == 32'h8002, "R6 zero keeps flag", d, 32'h8002);
    access(1, 4'h0, 2'b01, 32'h8002, d, e);
    access(0, 4'h0, 2'b01, 0, d, e); check(d == 32'h0002, "R6 one clears flag", d, 32'h0002);
    // R8 mis-sized control write discarded
    access(1, 4'h0, 2'b10, 32'h0AD6, d, e); check(e == 1, "R8 write rejected", {31'h0, e}, 1);
    access(0, 4'h0, 2'b01, 0, d, e); check(d == 32'h0002, "R8 control unchanged", d, 32'h0002);
    // R7 remaining selector values: reset, GPI, none
    for (int s = 0; s < 4; s++) begin
      if (s == 1) continue;
      access(1, 4'h0, 2'b01, 32'h0AD0 | (s << 1), d, e);
      access(1, 4'h4, 2'b10, 32'd3, d, e);
      access(1, 4'h0, 2'b01, 32'h8000 | (s << 1), d, e);
      idle(15);
      access(1, 4'h0, 2'b01, 32'h0AD6, d, e);
    end
    check(n_reset == 1, "R7 reset selected", n_reset, 1);
    check(n_gpi == 1, "R7 GPI selected", n_gpi, 1);
    check(n_nmi == 1, "R7 none selected drives nothing", n_nmi, 1);
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule